// File: doc/BRIEF.md
# Serial Audio Direction Status and Interrupt Controller

This block holds the control and status state for one direction of a serial audio port. Software sees it through a small 32-bit register port. The serial shifter and the FIFO stay outside the block. The shifter reports a word start and a frame sync error as single-cycle pulses. The FIFO reports an error pulse (underrun when transmitting, overflow when receiving) and also drives its current fill level.

From that level the block derives two live conditions: a warning (transmit FIFO empty, or receive FIFO full) and a data request that compares the level against a programmable watermark. The block combines the three recorded events and the two live conditions with per-source enables to drive one interrupt line. It drives a DMA request from the data-request condition. When software asks for it, it issues a one-cycle FIFO reset pulse.

Two registers are mapped at word addresses; all other addresses are unmapped.

The control/status word at address 0 has these fields:
- bit 31: direction enable.
- bit 24: FIFO reset command. It is write-only and always reads as 0.
- bits 20..16: flags.
- bits 12..8: interrupt enables. Each enable sits exactly 8 bits below its flag.
- bit 0: DMA enable.

The flag order from bit 16 upward is: data request, warning, FIFO error, sync error, word start.

The configuration word at address 1 holds the watermark in its low bits.

Top module: `audio_dir_csr`

## Requirements
- R1: After reset, dirEn, dmaEn, every interrupt enable, every recorded flag and the watermark are all 0, and irq, dmaReq and fifoRst are low. The control word then reads back only the live level flags; with level 0 on a transmit build, that value is 0x0003_0000.
- R2: When direction enable is 1, a pulse on wordStartEv, syncErrEv or fifoErrEv sets its flag (bits 20, 19 and 18 respectively). The flag is visible from the clock edge that samples the pulse and stays set until it is cleared.
- R3: A control-word write clears each of flag bits 20..18 that is written 1 and leaves each one written 0 unchanged. The same write loads bit 31, bit 0 and bits 12..8 from the write data.
- R4: If an event pulse and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R5: While direction enable is 0, event pulses are not recorded, and flags that are already set keep their values.
- R6: The warning flag (bit 17) and the data-request flag (bit 16) follow the FIFO level with no storage and cannot be changed by writes. On a transmit build, warning means level == 0 and data request means level <= watermark. On a receive build, warning means level == DEPTH and data request means level > watermark.
- R7: irq is high exactly when at least one flag in bits 20..16 is 1 and its enable at that bit minus 8 is also 1.
- R8: dmaReq is high exactly when DMA enable (bit 0) is 1 and the data-request condition holds.
- R9: Writing 1 to bit 24 of the control word drives fifoRst high for exactly the one cycle after the write edge. Bit 24 always reads back as 0.
- R10: The watermark is written and read back in bits [LVL_W-1:0] of the configuration word at address 1. All other bits of that word read as 0.
- R11: Writes to an unmapped address change no state and cause no fifoRst pulse. Reads from an unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | REG_AW | Word address for reads and writes |
| regWrEn | input | 1 | Write strobe, sampled on the clock edge |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| wordStartEv | input | 1 | Single-cycle pulse: a word starts on the serial line |
| syncErrEv | input | 1 | Single-cycle pulse: a frame sync error occurred |
| fifoErrEv | input | 1 | Single-cycle pulse: FIFO underrun or overflow |
| fifoLevel | input | LVL_W | Current FIFO fill level, 0..DEPTH |
| irq | output | 1 | Interrupt request (level) |
| dmaReq | output | 1 | DMA request (level) |
| fifoRst | output | 1 | One-cycle FIFO reset pulse |

## Verification
The assertions assume three things about the inputs:
- The event inputs are clean pulses, sampled only on clock edges.
- The FIFO level never exceeds DEPTH.
- The write strobe is synchronous and never overlaps reset.

The stimulus holds to this by changing inputs only on falling edges. It raises each event for exactly one cycle and keeps every level it drives within 0..32. The ignored-write cases are observed through register readback and the fifoRst port in the cycle right after the write.

// File: rtl/audio_csr_pkg.sv
`timescale 1ns/1ps
package audio_csr_pkg;
  // flag indices inside the five-bit flag field
  localparam int FLG_REQ  = 0;
  localparam int FLG_WARN = 1;
  localparam int FLG_FERR = 2;
  localparam int FLG_SERR = 3;
  localparam int FLG_WS   = 4;
  localparam int FLAG_CNT = 5;
  localparam int STICKY_CNT = 3;  // FERR, SERR, WS: the recorded events

  // control word layout
  localparam int DMA_EN_BIT   = 0;
  localparam int IE_LSB       = 8;
  localparam int FLAG_SHIFT   = 8;
  localparam int FLAG_LSB     = IE_LSB + FLAG_SHIFT;
  localparam int STICKY_LSB   = FLAG_LSB + FLG_FERR;
  localparam int FIFO_RST_BIT = 24;
  localparam int DIR_EN_BIT   = 31;

  // strobes handed from the decoder to the datapath
  typedef struct packed {
    logic wrCtrl;
    logic wrCfg;
    logic rstReq;
    logic rdCtrl;
    logic rdCfg;
  } csrStrobe_t;
endpackage

// File: rtl/audio_csr_decode.sv
`timescale 1ns/1ps
module audio_csr_decode
  import audio_csr_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output csrStrobe_t        strobe
);
  localparam logic [REG_AW-1:0] CTRL_ADDR = REG_AW'(0);
  localparam logic [REG_AW-1:0] CFG_ADDR  = REG_AW'(1);

  logic hitCtrl;
  logic hitCfg;

  always_comb begin
    hitCtrl = (regAddr == CTRL_ADDR);
    hitCfg  = (regAddr == CFG_ADDR);
    strobe.rdCtrl = hitCtrl;
    strobe.rdCfg  = hitCfg;
    strobe.wrCtrl = regWrEn && hitCtrl;
    strobe.wrCfg  = regWrEn && hitCfg;
    strobe.rstReq = regWrEn && hitCtrl && regWrData[FIFO_RST_BIT];
  end
endmodule

// File: rtl/audio_fifo_watch.sv
`timescale 1ns/1ps
module audio_fifo_watch #(
  parameter int DEPTH = 32,
  parameter bit IS_TX = 1'b1,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic [LVL_W-1:0] watermark,
  output logic             warnLvl,
  output logic             reqLvl
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  generate
    if (IS_TX) begin : g_tx
      always_comb begin
        warnLvl = (fifoLevel == '0);
        reqLvl  = (fifoLevel <= watermark);
      end
    end else begin : g_rx
      always_comb begin
        warnLvl = (fifoLevel >= FULL_LVL);
        reqLvl  = (fifoLevel > watermark);
      end
    end
  endgenerate
endmodule

// File: rtl/audio_csr_regs.sv
`timescale 1ns/1ps
module audio_csr_regs
  import audio_csr_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  csrStrobe_t            strobe,
  input  logic [31:0]           wrData,
  input  logic [STICKY_CNT-1:0] evIn,
  input  logic                  warnLvl,
  input  logic                  reqLvl,
  output logic [LVL_W-1:0]      watermark,
  output logic [31:0]           rdData,
  output logic                  irq,
  output logic                  dmaReq,
  output logic                  fifoRst
);
  logic                  dirEn;
  logic                  dmaEn;
  logic [FLAG_CNT-1:0]   ieBits;
  logic [STICKY_CNT-1:0] sticky;
  logic [STICKY_CNT-1:0] stickyNext;
  logic [STICKY_CNT-1:0] clrMask;
  logic [FLAG_CNT-1:0]   flags;
  logic [LVL_W-1:0]      wmReg;
  logic                  rstPulse;
  logic [31:0]           ctrlWord;
  logic [31:0]           cfgWord;

  always_comb begin
    clrMask    = strobe.wrCtrl ? wrData[STICKY_LSB +: STICKY_CNT] : '0;
    stickyNext = (sticky & ~clrMask) | (evIn & {STICKY_CNT{dirEn}});
    flags      = {sticky, warnLvl, reqLvl};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirEn    <= 1'b0;
      dmaEn    <= 1'b0;
      ieBits   <= '0;
      sticky   <= '0;
      wmReg    <= '0;
      rstPulse <= 1'b0;
    end else begin
      sticky   <= stickyNext;
      rstPulse <= strobe.rstReq;
      if (strobe.wrCtrl) begin
        dirEn  <= wrData[DIR_EN_BIT];
        dmaEn  <= wrData[DMA_EN_BIT];
        ieBits <= wrData[IE_LSB +: FLAG_CNT];
      end
      if (strobe.wrCfg) begin
        wmReg <= wrData[LVL_W-1:0];
      end
    end
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[DIR_EN_BIT] = dirEn;
    ctrlWord[DMA_EN_BIT] = dmaEn;
    ctrlWord[IE_LSB +: FLAG_CNT] = ieBits;
    ctrlWord[FLAG_LSB +: FLAG_CNT] = flags;
    cfgWord = '0;
    cfgWord[LVL_W-1:0] = wmReg;
    if (strobe.rdCtrl)     rdData = ctrlWord;
    else if (strobe.rdCfg) rdData = cfgWord;
    else                   rdData = '0;
  end

  assign watermark = wmReg;
  assign irq       = |(flags & ieBits);
  assign dmaReq    = dmaEn & reqLvl;
  assign fifoRst   = rstPulse;

  AST_EVENT_SET: assert property (@(posedge clk) disable iff (!rstN)
    dirEn |=> ((sticky & $past(evIn)) == $past(evIn))); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrCtrl && !dirEn) |=> ((sticky & $past(wrData[STICKY_LSB +: STICKY_CNT])) == '0)); // R3
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!dirEn && !strobe.wrCtrl) |=> $stable(sticky)); // R5
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ieBits != '0)); // R7
  AST_DMA_GATE: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> dmaEn); // R8
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    fifoRst |=> !fifoRst); // R9
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    fifoRst |-> $past(strobe.rstReq)); // R9
endmodule

// File: rtl/audio_dir_csr.sv
`timescale 1ns/1ps
module audio_dir_csr
  import audio_csr_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter bit IS_TX  = 1'b1,
  parameter int REG_AW = 3,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              wordStartEv,
  input  logic              syncErrEv,
  input  logic              fifoErrEv,
  input  logic [LVL_W-1:0]  fifoLevel,
  output logic              irq,
  output logic              dmaReq,
  output logic              fifoRst
);
  csrStrobe_t            strobe;
  logic [LVL_W-1:0]      watermark;
  logic                  warnLvl;
  logic                  reqLvl;
  logic [STICKY_CNT-1:0] evIn;

  assign evIn = {wordStartEv, syncErrEv, fifoErrEv};

  audio_csr_decode #(.REG_AW(REG_AW)) i_decode (
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .strobe   (strobe)
  );

  audio_fifo_watch #(.DEPTH(DEPTH), .IS_TX(IS_TX), .LVL_W(LVL_W)) i_watch (
    .fifoLevel(fifoLevel),
    .watermark(watermark),
    .warnLvl  (warnLvl),
    .reqLvl   (reqLvl)
  );

  audio_csr_regs #(.LVL_W(LVL_W)) i_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (regWrData),
    .evIn     (evIn),
    .warnLvl  (warnLvl),
    .reqLvl   (reqLvl),
    .watermark(watermark),
    .rdData   (regRdData),
    .irq      (irq),
    .dmaReq   (dmaReq),
    .fifoRst  (fifoRst)
  );
endmodule

// File: tb/test_audio_dir_csr.sv
`timescale 1ns/1ps
module test_audio_dir_csr;
  localparam int LVL_W = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        wordStartEv = 1'b0;
  logic        syncErrEv = 1'b0;
  logic        fifoErrEv = 1'b0;
  logic [LVL_W-1:0] fifoLevel = '0;
  logic        irq;
  logic        dmaReq;
  logic        fifoRst;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  audio_dir_csr i_audio_dir_csr (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .wordStartEv(wordStartEv), .syncErrEv(syncErrEv), .fifoErrEv(fifoErrEv),
    .fifoLevel(fifoLevel), .irq(irq), .dmaReq(dmaReq), .fifoRst(fifoRst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    #1;
  endtask

  task automatic rdCheck(input string req, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    check(req, regRdData, exp);
  endtask

  // mask bits: 2 word start, 1 sync error, 0 FIFO error
  task automatic pulse(input logic [2:0] m);
    @(negedge clk);
    {wordStartEv, syncErrEv, fifoErrEv} = m;
    @(negedge clk);
    {wordStartEv, syncErrEv, fifoErrEv} = 3'b000;
    #1;
  endtask

  task automatic t_reset;
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 dmaReq", {31'b0, dmaReq}, 32'h0);
    check("R1 fifoRst", {31'b0, fifoRst}, 32'h0);
    rdCheck("R1 ctrl", 3'd0, 32'h0003_0000);
    rdCheck("R1 cfg", 3'd1, 32'h0);
  endtask

  task automatic t_levels;
    wr(3'd1, 32'hFFFF_FF08);
    rdCheck("R10 watermark", 3'd1, 32'h0000_0008);
    fifoLevel = 6'd5;
    rdCheck("R6 level below wm", 3'd0, 32'h0001_0000);
    fifoLevel = 6'd8;
    rdCheck("R6 level at wm", 3'd0, 32'h0001_0000);
    fifoLevel = 6'd9;
    rdCheck("R6 level above wm", 3'd0, 32'h0);
    wr(3'd0, 32'h0003_0000);
    rdCheck("R6 level flags not writable", 3'd0, 32'h0);
    fifoLevel = 6'd0;
    rdCheck("R6 empty", 3'd0, 32'h0003_0000);
    fifoLevel = 6'd20;
  endtask

  task automatic t_sticky;
    wr(3'd0, 32'h8000_0000);
    pulse(3'b100);
    rdCheck("R2 word start", 3'd0, 32'h8010_0000);
    pulse(3'b011);
    rdCheck("R2 sync and fifo error", 3'd0, 32'h801C_0000);
    wr(3'd0, 32'h8000_0000);
    rdCheck("R3 write 0 keeps", 3'd0, 32'h801C_0000);
    wr(3'd0, 32'h8008_0000);
    rdCheck("R3 clear sync only", 3'd0, 32'h8014_0000);
    wr(3'd0, 32'h801C_0000);
    rdCheck("R3 clear all", 3'd0, 32'h8000_0000);
  endtask

  task automatic t_setwins;
    pulse(3'b100);
    @(negedge clk);
    regAddr = 3'd0; regWrData = 32'h8010_0000; regWrEn = 1'b1; wordStartEv = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; wordStartEv = 1'b0;
    rdCheck("R4 set wins", 3'd0, 32'h8010_0000);
    wr(3'd0, 32'h8010_0000);
    rdCheck("R4 cleared after", 3'd0, 32'h8000_0000);
  endtask

  task automatic t_disable;
    pulse(3'b001);
    wr(3'd0, 32'h0000_0000);
    pulse(3'b111);
    rdCheck("R5 disabled keeps old, ignores new", 3'd0, 32'h0004_0000);
    wr(3'd0, 32'h0004_0000);
    rdCheck("R5 cleanup", 3'd0, 32'h0);
  endtask

  task automatic t_irq;
    wr(3'd0, 32'h8000_0400);
    check("R7 enabled no flag", {31'b0, irq}, 32'h0);
    pulse(3'b001);
    check("R7 fifo error irq", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h8004_0100);
    check("R7 other enable only", {31'b0, irq}, 32'h0);
    @(negedge clk); fifoLevel = 6'd0; #1;
    check("R7 level request irq", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h0000_0000);
    check("R7 enables off", {31'b0, irq}, 32'h0);
    @(negedge clk); fifoLevel = 6'd20;
  endtask

  task automatic t_dma;
    @(negedge clk); fifoLevel = 6'd3; #1;
    check("R8 dma disabled", {31'b0, dmaReq}, 32'h0);
    wr(3'd0, 32'h0000_0001);
    check("R8 dma enabled", {31'b0, dmaReq}, 32'h1);
    @(negedge clk); fifoLevel = 6'd20; #1;
    check("R8 above watermark", {31'b0, dmaReq}, 32'h0);
    wr(3'd0, 32'h0000_0000);
  endtask

  task automatic t_fiforst;
    wr(3'd0, 32'h0100_0000);
    check("R9 pulse high", {31'b0, fifoRst}, 32'h1);
    check("R9 reads 0", regRdData, 32'h0);
    @(negedge clk); #1;
    check("R9 pulse one cycle", {31'b0, fifoRst}, 32'h0);
  endtask

  task automatic t_unmapped;
    wr(3'd3, 32'hFFFF_FFFF);
    check("R11 no reset pulse", {31'b0, fifoRst}, 32'h0);
    rdCheck("R11 read 0", 3'd3, 32'h0);
    rdCheck("R11 ctrl untouched", 3'd0, 32'h0);
    rdCheck("R11 cfg untouched", 3'd1, 32'h0000_0008);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rstN = 1'b1;
    t_reset();
    t_levels();
    t_sticky();
    t_setwins();
    t_disable();
    t_irq();
    t_dma();
    t_fiforst();
    t_unmapped();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule